// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between an on-chip client and an external asynchronous static RAM of 16,384 four-bit words. The client sends one-word read or write requests through a valid/ready handshake. The controller turns each request into the chip-enable, output-enable and write-enable sequence that the memory expects. The memory's bidirectional data pins appear as three lines: a driven value, a sampled value and a drive-enable. A pad cell outside the block joins them.

Every minimum timing window is a clock-cycle count set by a parameter. Each count is the nanosecond figure divided by the clock period and rounded up. The windows are the write strobe width, the data setup before the strobe ends, the read access time and the recovery time after standby.

A standby input deselects the memory for low-power retention. When the input is released, the controller waits a full recovery window before it accepts the next access. Read data comes back on a separate port with a one-cycle valid pulse.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset the controller holds chip enable, output enable and write enable high (inactive). It keeps the data drive-enable low and `rd_valid` low, and it raises `req_ready`.
- R2: A write (`req_write`=1) holds chip enable and write enable low together, with output enable high, for exactly max(WR_PULSE_CYC, DSETUP_CYC) consecutive cycles (3 by default). During every one of those cycles the drive-enable is high and the request's data is on `mem_dq_out`, so the memory stores that data at the address.
- R3: A read (`req_write`=0) holds chip enable and output enable low, with write enable high and drive-enable low, for exactly RD_ACCESS_CYC cycles. `mem_dq_in` is sampled at the end of the last of those cycles. The sampled value appears on `rd_data` with `rd_valid` high in the following cycle.
- R4: While chip enable stays low through consecutive cycles, `mem_addr` and `mem_dq_out` do not change.
- R5: The drive-enable is high only in cycles where write enable is low. It is never high in the cycle directly after a cycle with output enable low, so at least one cycle with every strobe high separates a read from a following write.
- R6: `req_ready` is high only while no access, standby or recovery is in progress, and in such cycles all strobes are high. A request is taken only in a cycle with `req_valid` and `req_ready` both high.
- R7: `sleep_req` is taken only when the controller is ready, and it wins over a request made in the same cycle. From the next cycle, as long as it stays high, chip enable stays high and `req_ready` stays low, and a pending request is ignored.
- R8: After `sleep_req` falls, `req_ready` stays low and chip enable stays high for exactly RECOVER_CYC cycles (3 by default). Only then can a request be taken.
- R9: `rd_valid` is a single-cycle pulse. It never follows a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 4 | Write data |
| req_ready | output | 1 | Controller can take a request this cycle |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read result |
| rd_data | output | 4 | Read result |
| sleep_req | input | 1 | Standby request, level sensitive |
| mem_addr | output | 14 | Memory address lines |
| mem_dq_out | output | 4 | Value to drive on the data pins |
| mem_dq_in | input | 4 | Value sampled from the data pins |
| mem_dq_oe | output | 1 | Drive-enable for the data pins |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
The bench's memory model returns the inverted word until the read strobes have been low for the full access window. A controller that samples one cycle early therefore returns wrong data. A write pulse that is one cycle short or long is caught by the strobe-width monitor.

A read is followed at once by a write to exercise the bus turnaround. A design without the quiet cycle would enable its drivers while the memory still drives the bus.

The standby test holds a request pending through sleep and through the recovery window, and it raises sleep and a request in the same cycle. A design that wakes early, or lets the request win, would lower chip enable too soon.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WRITE = 3'd1,
        ST_READ  = 3'd2,
        ST_SLEEP = 3'd3,
        ST_WAKE  = 3'd4
    } ctl_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STROBES_QUIET = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int count_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic strobe_t decode_strobes(input ctl_state_e s);
        strobe_t r;
        r = STROBES_QUIET;
        case (s)
            ST_WRITE: begin
                r.ce_n  = 1'b0;
                r.we_n  = 1'b0;
                r.drive = 1'b1;
            end
            ST_READ: begin
                r.ce_n = 1'b0;
                r.oe_n = 1'b0;
            end
            default: r = STROBES_QUIET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int WR_LEN   = 3,
    parameter int RD_LEN   = 3,
    parameter int WAKE_LEN = 3,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             sleep_req,
    input  logic             cnt_zero,
    output ctl_state_e       state,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture
);
    localparam logic [CNT_W-1:0] WR_LOAD   = CNT_W'(WR_LEN - 1);
    localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_LEN - 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_LEN - 1);

    ctl_state_e state_q, state_d;

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (sleep_req) begin
                    state_d = ST_SLEEP;
                end else if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_write) begin
                        state_d  = ST_WRITE;
                        load_val = WR_LOAD;
                    end else begin
                        state_d  = ST_READ;
                        load_val = RD_LOAD;
                    end
                end
            end
            ST_WRITE: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            ST_READ: begin
                if (cnt_zero) begin
                    state_d = ST_IDLE;
                    capture = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (!sleep_req) begin
                    state_d  = ST_WAKE;
                    load     = 1'b1;
                    load_val = WAKE_LOAD;
                end
            end
            ST_WAKE: begin
                if (cnt_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int AW = 14,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          capture,
    input  logic [DW-1:0] mem_dq_in,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dq_out,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;
    logic          rvalid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) rdata_q <= mem_dq_in;
        end
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rd_data    = rdata_q;
    assign rd_valid   = rvalid_q;

    // R9: result strobe never lasts two cycles
    assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 14,
    parameter int DATA_W        = 4,
    parameter int WR_PULSE_CYC  = 3,
    parameter int DSETUP_CYC    = 2,
    parameter int RD_ACCESS_CYC = 3,
    parameter int RECOVER_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              sleep_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);
    localparam int WR_LEN   = imax(imax(WR_PULSE_CYC, DSETUP_CYC), 1);
    localparam int RD_LEN   = imax(RD_ACCESS_CYC, 1);
    localparam int WAKE_LEN = imax(RECOVER_CYC, 1);
    localparam int CNT_W    = count_width(imax(imax(WR_LEN, RD_LEN), WAKE_LEN));

    ctl_state_e       state;
    strobe_t          strb;
    logic             accept;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             cnt_zero;
    logic             capture;

    sram_seq_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .zero     (cnt_zero)
    );

    sram_seq_fsm #(
        .WR_LEN   (WR_LEN),
        .RD_LEN   (RD_LEN),
        .WAKE_LEN (WAKE_LEN),
        .CNT_W    (CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .sleep_req (sleep_req),
        .cnt_zero  (cnt_zero),
        .state     (state),
        .accept    (accept),
        .load      (load),
        .load_val  (load_val),
        .capture   (capture)
    );

    sram_data_path #(.AW(ADDR_W), .DW(DATA_W)) i_data (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .capture    (capture),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    assign strb      = decode_strobes(state);
    assign mem_ce_n  = strb.ce_n;
    assign mem_oe_n  = strb.oe_n;
    assign mem_we_n  = strb.we_n;
    assign mem_dq_oe = strb.drive;
    assign req_ready = (state == ST_IDLE);

    // Width of each write-enable low run, for the R2 check
    logic [15:0] we_run_q;
    always_ff @(posedge clk) begin
        if (rst)            we_run_q <= '0;
        else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
        else                we_run_q <= '0;
    end

    assert_we_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_run_q == 16'(WR_LEN)));

    assert_rd_source_R3: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(!mem_oe_n) && $past(!mem_ce_n) && $past(mem_we_n)));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

    assert_turnaround_R5: assert property (@(posedge clk) disable iff (rst)
        $past(!mem_oe_n) |-> !mem_dq_oe);

    assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    assert_sleep_take_R7: assert property (@(posedge clk) disable iff (rst)
        (req_ready && sleep_req) |=> (mem_ce_n && !req_ready));
endmodule

// File: tb/test_sram_strobe_ctrl.sv
module test_sram_strobe_ctrl;
    localparam int WR_PULSE_CYC  = 3;
    localparam int DSETUP_CYC    = 2;
    localparam int RD_ACCESS_CYC = 3;
    localparam int RECOVER_CYC   = 3;
    localparam int WR_LEN = (WR_PULSE_CYC > DSETUP_CYC) ? WR_PULSE_CYC : DSETUP_CYC;

    // vector: [18] write, [17:4] address, [3:0] write data or expected read data
    localparam int NVEC = 9;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 14'h0000, 4'hA},
        {1'b1, 14'h3FFF, 4'h5},
        {1'b1, 14'h1234, 4'hC},
        {1'b0, 14'h0000, 4'hA},
        {1'b0, 14'h3FFF, 4'h5},
        {1'b1, 14'h0000, 4'h3},
        {1'b0, 14'h0000, 4'h3},
        {1'b0, 14'h1234, 4'hC},
        {1'b0, 14'h0777, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        sleep_req = 1'b0;
    logic        req_ready, rd_valid, mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;
    logic [3:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [13:0] mem_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sram_strobe_ctrl #(
        .WR_PULSE_CYC(WR_PULSE_CYC), .DSETUP_CYC(DSETUP_CYC),
        .RD_ACCESS_CYC(RD_ACCESS_CYC), .RECOVER_CYC(RECOVER_CYC)
    ) i_sram_strobe_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .sleep_req(sleep_req),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- memory model and monitors (sampled at negedge) -------
    logic [3:0] mdl [logic [13:0]];
    int         rd_run = 0;
    int         we_run = 0;
    logic       prev_oe_low = 1'b0;
    logic       prev_ce_low = 1'b0;
    logic [13:0] prev_addr = '0;
    logic [3:0]  prev_dout = '0;
    logic [3:0]  model_word;

    always_comb begin
        model_word = mdl.exists(mem_addr) ? mdl[mem_addr] : 4'h0;
        mem_dq_in  = (rd_run >= RD_ACCESS_CYC) ? model_word : ~model_word;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_ce_n && !mem_we_n) begin
                mdl[mem_addr] = mem_dq_out;
                chk(mem_dq_oe && mem_oe_n, "R2 drive during write", {30'd0, mem_dq_oe, mem_oe_n}, 32'h3);
            end
            if (!mem_we_n) we_run++;
            else if (we_run != 0) begin
                chk(we_run == WR_LEN, "R2 write pulse width", we_run, WR_LEN);
                we_run = 0;
            end
            if (mem_dq_oe)
                chk(!mem_we_n && !prev_oe_low, "R5 drive only in write, after quiet cycle",
                    {30'd0, mem_we_n, prev_oe_low}, 32'h0);
            if (!mem_ce_n && prev_ce_low)
                chk(mem_addr == prev_addr && mem_dq_out == prev_dout, "R4 address/data hold",
                    {14'd0, mem_addr, mem_dq_out}, {14'd0, prev_addr, prev_dout});
            if (!mem_ce_n && !mem_oe_n) rd_run++;
            else rd_run = 0;
            prev_oe_low = !mem_oe_n;
            prev_ce_low = !mem_ce_n;
            prev_addr   = mem_addr;
            prev_dout   = mem_dq_out;
        end
    end

    task automatic wait_ready();
        while (!req_ready) @(negedge clk);
    endtask

    task automatic do_op(input logic wr, input logic [13:0] a, input logic [3:0] d);
        wait_ready();
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) begin
            for (int k = 1; k <= WR_LEN + 1; k++) begin
                @(negedge clk);
                if (k == 1) begin
                    req_valid = 1'b0;
                    chk(!mem_ce_n && !mem_we_n && mem_oe_n && mem_dq_oe && mem_dq_out == d && mem_addr == a,
                        "R2 write strobes", {27'd0, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe, 1'b0},
                        {27'd0, 5'b00110});
                end
                chk(!rd_valid, "R9 no result after write", rd_valid, 0);
                chk(req_ready == (k == WR_LEN + 1), "R6 ready during write", req_ready, (k == WR_LEN + 1));
            end
        end else begin
            for (int k = 1; k <= RD_ACCESS_CYC + 1; k++) begin
                @(negedge clk);
                if (k == 1) begin
                    req_valid = 1'b0;
                    chk(!mem_ce_n && !mem_oe_n && mem_we_n && !mem_dq_oe && mem_addr == a,
                        "R3 read strobes", {28'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
                        {28'd0, 4'b0010});
                end
                chk(req_ready == (k == RD_ACCESS_CYC + 1), "R6 ready during read", req_ready,
                    (k == RD_ACCESS_CYC + 1));
                if (k <= RD_ACCESS_CYC)
                    chk(!rd_valid, "R3 result not early", rd_valid, 0);
                else
                    chk(rd_valid && rd_data == d, "R3 read data", {27'd0, rd_valid, rd_data},
                        {27'd0, 1'b1, d});
            end
            @(negedge clk);
            chk(!rd_valid, "R9 single-cycle result", rd_valid, 0);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid && req_ready,
            "R1 reset state", {26'd0, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, rd_valid, req_ready},
            {26'd0, 6'b111001});

        for (int i = 0; i < NVEC; i++)
            do_op(VEC[i][18], VEC[i][17:4], VEC[i][3:0]);

        // R7: sleep and request in the same cycle, sleep wins
        wait_ready();
        sleep_req = 1'b1;
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 14'h0000;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk(mem_ce_n && !req_ready, "R7 standby holds memory deselected",
                {30'd0, mem_ce_n, req_ready}, 32'h2);
        end
        // R8: recovery window with the request still pending
        sleep_req = 1'b0;
        for (int k = 1; k <= RECOVER_CYC; k++) begin
            @(negedge clk);
            chk(!req_ready && mem_ce_n, "R8 recovery window", {30'd0, req_ready, mem_ce_n}, 32'h1);
        end
        @(negedge clk);
        chk(req_ready && mem_ce_n, "R8 ready after recovery", {30'd0, req_ready, mem_ce_n}, 32'h3);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_ce_n && !mem_oe_n, "R8 first access after wake", {30'd0, mem_ce_n, mem_oe_n}, 32'h0);
        for (int k = 2; k <= RD_ACCESS_CYC + 1; k++) @(negedge clk);
        chk(rd_valid && rd_data == 4'h3, "R3 read after wake", {27'd0, rd_valid, rd_data}, {27'd0, 5'h13});

        // R5: write straight after a read still gets a quiet cycle (monitor checks)
        do_op(1'b0, 14'h3FFF, 4'h5);
        do_op(1'b1, 14'h3FFF, 4'h9);
        do_op(1'b0, 14'h3FFF, 4'h9);

        repeat (2) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule